// File: doc/BRIEF.md
# Host/DSP Byte-Word Mailbox

This block couples a 16-bit register bus on a DSP core to an 8-bit host bus with eight byte addresses. Each direction has two buffer stages and an empty/full flag at each end. A word moves on to the next stage by itself as soon as the sender-side stage is loaded and the receiver-side stage is free. The host writes a word as a high byte then a low byte, and reads a word back the same way. The DSP moves whole words.

The block also carries a few control signals between the two sides. The host can post a command carrying a 5-bit vector. Two flag bits run from the host to the DSP and two run the other way. Three level interrupt requests go to the DSP, one each for received data, transmit space and a pending command. Both buses run on one clock and use single-cycle read and write strobes. Read data is combinational from the address, and any flag that a read clears changes at the clock edge that ends the read cycle.

Top module: `hostif_mailbox`

## Requirements
- R1: After reset, the host-side status register (host address 2) reads 0x02, meaning transmit-empty is 1 and receive-full is 0. The command register (host address 1) reads 0x16. The DSP control register (DSP select 0) reads 0. The DSP status register (DSP select 1) reads 0x0002, meaning only the DSP transmit-empty bit (bit 1) is set. All three interrupt outputs are 0.
- R2: A host write to address 6 (high byte) is stored only while host transmit-empty (host status bit 1) is 1. A host write to address 7 (low byte) under the same condition stores the byte and clears transmit-empty. Data byte writes made while transmit-empty is 0 are dropped.
- R3: When host transmit-empty and DSP receive-full (DSP status bit 0) are both 0, the next clock edge loads {high byte, low byte} into the DSP receive word and sets both flags.
- R4: A DSP read of select 2 returns the receive word and clears DSP receive-full when that flag is set. When the flag is clear, the read returns 0xBEEF.
- R5: A DSP write to select 2 stores the word and clears DSP transmit-empty. When DSP transmit-empty and host receive-full (host status bit 0) are both 0, the next edge splits the word into the host high and low receive bytes and sets both flags.
- R6: A host read of address 6 or 7 returns 0xBF while host receive-full is 0. A read of address 7 while receive-full is 1 clears it, and a read of address 6 never clears it.
- R7: The host command register holds the command bit in bit 7 and the vector in bits 4:0. The command bit appears as DSP status bit 2. A host write to this register sets bit 7 to the written value. The cmd_ack input clears the command bit, and a host write in the same cycle takes priority over the ack.
- R8: Host control register bits 3 and 4 are written by the host (address 0) and appear as DSP status bits 3 and 4. DSP control bits 3 and 4 appear as host status bits 3 and 4. Host control bits 0 and 1 are stored and read back.
- R9: irq_rx equals DSP receive-full AND control bit 0. irq_tx equals DSP transmit-empty AND control bit 1. irq_cmd equals the command bit AND control bit 2.
- R10: Host writes to addresses 2, 4 and 5 change no state. Addresses 4 and 5 read 0. Address 3 is a plain byte register that resets to 0. DSP status bit 7 always reads 0.
- R11: If a DSP data write lands in the same cycle as a pending DSP-to-host transfer, the old word moves to the host bytes and the new word stays buffered with transmit-empty 0. Neither word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both buses |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_sel | input | 2 | DSP register select: 0 control, 1 status, 2 data, 3 unused |
| d_wr | input | 1 | DSP write strobe |
| d_rd | input | 1 | DSP read strobe |
| d_wdata | input | 2*HB_W | DSP write data |
| d_rdata | output | 2*HB_W | DSP read data for the selected register |
| cmd_ack | input | 1 | DSP acknowledge of the host command |
| irq_rx | output | 1 | Receive-data interrupt request |
| irq_tx | output | 1 | Transmit-space interrupt request |
| irq_cmd | output | 1 | Host-command interrupt request |
| h_addr | input | 3 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | HB_W | Host write data |
| h_rdata | output | HB_W | Host read data for the addressed byte |

## Verification
Several pairs of events can fall on the same clock edge. One pair is a DSP data write and the automatic DSP-to-host transfer it follows. Another is a host low-byte read and a DSP write that refills the path. A third is cmd_ack and a host command write. Back-to-back DSP writes with the host side empty force the first pair. The bench judges the result by reading both words out through the host bytes in order. Random traffic from a seeded generator mixes all strobes with acks, and a bench-side model of the requirements predicts every read and every interrupt level in each cycle.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

  typedef enum logic [2:0] {
    HA_CTRL  = 3'd0,
    HA_CMD   = 3'd1,
    HA_STAT  = 3'd2,
    HA_VECT  = 3'd3,
    HA_ZERO  = 3'd4,
    HA_RSVD  = 3'd5,
    HA_BHI   = 3'd6,
    HA_BLO   = 3'd7
  } host_addr_e;

  typedef enum logic [1:0] {
    DS_CTRL = 2'd0,
    DS_STAT = 2'd1,
    DS_DATA = 2'd2,
    DS_NONE = 2'd3
  } dsp_sel_e;

  // bit positions shared by several registers
  localparam int unsigned B_FULL   = 0;
  localparam int unsigned B_EMPTY  = 1;
  localparam int unsigned B_CMD    = 2;
  localparam int unsigned B_FLAG_A = 3;
  localparam int unsigned B_FLAG_B = 4;
  localparam int unsigned B_DMA    = 7;
  localparam int unsigned CTL_W    = 5;

endpackage

// File: rtl/hmb_rst_sync.sv
module hmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/hmb_h2d_path.sv
module hmb_h2d_path #(
  parameter int HB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HB_W-1:0]   wdata,
  input  logic              rd_word,
  output logic              txde,
  output logic              hrdf,
  output logic [2*HB_W-1:0] rx_word
);
  localparam int DW = 2 * HB_W;

  logic [HB_W-1:0] txh_q, txl_q;
  logic [DW-1:0]   rxw_q;
  logic            txde_q, hrdf_q;
  logic            txde_d, hrdf_d;
  logic            txh_en, txl_en, xfer;

  always_comb begin
    xfer   = !txde_q && !hrdf_q;
    txh_en = wr_hi && txde_q;
    txl_en = wr_lo && txde_q;
    txde_d = txde_q;
    hrdf_d = hrdf_q;
    if (txl_en)            txde_d = 1'b0;
    if (rd_word && hrdf_q) hrdf_d = 1'b0;
    if (xfer) begin
      txde_d = 1'b1;
      hrdf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txde_q <= 1'b1;
      hrdf_q <= 1'b0;
    end else begin
      txde_q <= txde_d;
      hrdf_q <= hrdf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh_q <= '0;
      txl_q <= '0;
      rxw_q <= '0;
    end else begin
      if (txh_en) txh_q <= wdata;
      if (txl_en) txl_q <= wdata;
      if (xfer)   rxw_q <= {txh_q, txl_q};
    end
  end

  assign txde    = txde_q;
  assign hrdf    = hrdf_q;
  assign rx_word = rxw_q;

  // R3: both flags clear means the word moves on at the next edge
  a_r3_auto_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!txde_q && !hrdf_q) |=> (txde_q && hrdf_q));

  // R2: a low byte offered while the stage is loaded is dropped
  a_r2_drop_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !txde_q) |=> $stable(txl_q));

  // R4: consuming a full word empties the receive stage
  a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && hrdf_q) |=> !hrdf_q);
endmodule

// File: rtl/hmb_d2h_path.sv
module hmb_d2h_path #(
  parameter int HB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word,
  input  logic [2*HB_W-1:0] wdata,
  input  logic              rd_lo,
  output logic              htde,
  output logic              rxdf,
  output logic [HB_W-1:0]   rx_hi,
  output logic [HB_W-1:0]   rx_lo
);
  localparam int DW    = 2 * HB_W;
  localparam int LANES = DW / HB_W;

  logic [DW-1:0] txw_q;
  logic [DW-1:0] rx_bytes;
  logic          htde_q, rxdf_q;
  logic          htde_d, rxdf_d;
  logic          xfer;

  always_comb begin
    xfer   = !htde_q && !rxdf_q;
    htde_d = htde_q;
    rxdf_d = rxdf_q;
    if (rd_lo && rxdf_q) rxdf_d = 1'b0;
    if (xfer) begin
      htde_d = 1'b1;
      rxdf_d = 1'b1;
    end
    // a new word written in the transfer cycle refills the stage
    if (wr_word) htde_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htde_q <= 1'b1;
      rxdf_q <= 1'b0;
      txw_q  <= '0;
    end else begin
      htde_q <= htde_d;
      rxdf_q <= rxdf_d;
      if (wr_word) txw_q <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HB_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (xfer) lane_q <= txw_q[g*HB_W +: HB_W];
    end
    assign rx_bytes[g*HB_W +: HB_W] = lane_q;
  end

  assign htde  = htde_q;
  assign rxdf  = rxdf_q;
  assign rx_hi = rx_bytes[DW-1 -: HB_W];
  assign rx_lo = rx_bytes[HB_W-1:0];

  // R5: a DSP word write always leaves the send stage loaded
  a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word |=> !htde_q);

  // R6: taking the low byte frees the host receive stage
  a_r6_low_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && rxdf_q) |=> !rxdf_q);

  // R11: a transfer fills the host bytes even when a new word lands
  a_r11_move_and_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (!htde_q && !rxdf_q && wr_word) |=> (rxdf_q && !htde_q));
endmodule

// File: rtl/hmb_host_ctl.sv
module hmb_host_ctl #(
  parameter int              HB_W    = 8,
  parameter int              VEC_W   = 5,
  parameter logic [VEC_W-1:0] RST_VEC = 5'h16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_cmd,
  input  logic            wr_vect,
  input  logic [HB_W-1:0] wdata,
  input  logic            cmd_ack,
  output logic [HB_W-1:0] ctrl_byte,
  output logic [HB_W-1:0] cmd_byte,
  output logic [HB_W-1:0] vect_byte,
  output logic            flag_a,
  output logic            flag_b,
  output logic            cmd_pend
);
  import hmb_pkg::*;

  localparam int CMD_BIT = HB_W - 1;

  logic             req_rx_q, req_tx_q, fa_q, fb_q, hc_q;
  logic             req_rx_d, req_tx_d, fa_d, fb_d, hc_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [HB_W-1:0]  ivr_q, ivr_d;

  always_comb begin
    req_rx_d = req_rx_q;
    req_tx_d = req_tx_q;
    fa_d     = fa_q;
    fb_d     = fb_q;
    hc_d     = hc_q;
    vec_d    = vec_q;
    ivr_d    = ivr_q;
    if (wr_ctrl) begin
      req_rx_d = wdata[B_FULL];
      req_tx_d = wdata[B_EMPTY];
      fa_d     = wdata[B_FLAG_A];
      fb_d     = wdata[B_FLAG_B];
    end
    if (cmd_ack) hc_d = 1'b0;
    if (wr_cmd) begin
      hc_d  = wdata[CMD_BIT];
      vec_d = wdata[VEC_W-1:0];
    end
    if (wr_vect) ivr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_rx_q <= 1'b0;
      req_tx_q <= 1'b0;
      fa_q     <= 1'b0;
      fb_q     <= 1'b0;
      hc_q     <= 1'b0;
      vec_q    <= RST_VEC;
      ivr_q    <= '0;
    end else begin
      req_rx_q <= req_rx_d;
      req_tx_q <= req_tx_d;
      fa_q     <= fa_d;
      fb_q     <= fb_d;
      hc_q     <= hc_d;
      vec_q    <= vec_d;
      ivr_q    <= ivr_d;
    end
  end

  always_comb begin
    ctrl_byte           = '0;
    ctrl_byte[B_FULL]   = req_rx_q;
    ctrl_byte[B_EMPTY]  = req_tx_q;
    ctrl_byte[B_FLAG_A] = fa_q;
    ctrl_byte[B_FLAG_B] = fb_q;
    cmd_byte            = '0;
    cmd_byte[CMD_BIT]   = hc_q;
    cmd_byte[VEC_W-1:0] = vec_q;
  end

  assign vect_byte = ivr_q;
  assign flag_a    = fa_q;
  assign flag_b    = fb_q;
  assign cmd_pend  = hc_q;

  // R7: an acknowledge with no competing host write retires the command
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && !wr_cmd) |=> !hc_q);

  // R7: a host command write with bit set wins over a same-cycle ack
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[CMD_BIT]) |=> hc_q);
endmodule

// File: rtl/hostif_mailbox.sv
module hostif_mailbox #(
  parameter int               HB_W       = 8,
  parameter int               VEC_W      = 5,
  parameter logic [VEC_W-1:0] RST_VEC    = 5'h16,
  parameter logic [2*HB_W-1:0] EMPTY_WORD = 16'hBEEF,
  parameter logic [HB_W-1:0]  EMPTY_BYTE = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        d_sel,
  input  logic              d_wr,
  input  logic              d_rd,
  input  logic [2*HB_W-1:0] d_wdata,
  output logic [2*HB_W-1:0] d_rdata,
  input  logic              cmd_ack,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_cmd,
  input  logic [2:0]        h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [HB_W-1:0]   h_wdata,
  output logic [HB_W-1:0]   h_rdata
);
  import hmb_pkg::*;

  localparam int DW = 2 * HB_W;

  logic rst_q_n;

  logic h_wr_ctrl, h_wr_cmd, h_wr_vect, h_wr_hi, h_wr_lo, h_rd_lo;
  logic d_wr_ctl, d_wr_data, d_rd_data;

  logic              txde, hrdf, htde, rxdf;
  logic [DW-1:0]     rx_word;
  logic [HB_W-1:0]   rx_hi, rx_lo;
  logic [HB_W-1:0]   ctrl_byte, cmd_byte, vect_byte;
  logic              flag_a, flag_b, cmd_pend;

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              ctl_en;

  hmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  // strobe decode
  always_comb begin
    h_wr_ctrl = h_wr && (host_addr_e'(h_addr) == HA_CTRL);
    h_wr_cmd  = h_wr && (host_addr_e'(h_addr) == HA_CMD);
    h_wr_vect = h_wr && (host_addr_e'(h_addr) == HA_VECT);
    h_wr_hi   = h_wr && (host_addr_e'(h_addr) == HA_BHI);
    h_wr_lo   = h_wr && (host_addr_e'(h_addr) == HA_BLO);
    h_rd_lo   = h_rd && (host_addr_e'(h_addr) == HA_BLO);
    d_wr_ctl  = d_wr && (dsp_sel_e'(d_sel) == DS_CTRL);
    d_wr_data = d_wr && (dsp_sel_e'(d_sel) == DS_DATA);
    d_rd_data = d_rd && (dsp_sel_e'(d_sel) == DS_DATA);
  end

  hmb_h2d_path #(.HB_W(HB_W)) u_h2d (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_hi   (h_wr_hi),
    .wr_lo   (h_wr_lo),
    .wdata   (h_wdata),
    .rd_word (d_rd_data),
    .txde    (txde),
    .hrdf    (hrdf),
    .rx_word (rx_word)
  );

  hmb_d2h_path #(.HB_W(HB_W)) u_d2h (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_word (d_wr_data),
    .wdata   (d_wdata),
    .rd_lo   (h_rd_lo),
    .htde    (htde),
    .rxdf    (rxdf),
    .rx_hi   (rx_hi),
    .rx_lo   (rx_lo)
  );

  hmb_host_ctl #(.HB_W(HB_W), .VEC_W(VEC_W), .RST_VEC(RST_VEC)) u_hctl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_ctrl   (h_wr_ctrl),
    .wr_cmd    (h_wr_cmd),
    .wr_vect   (h_wr_vect),
    .wdata     (h_wdata),
    .cmd_ack   (cmd_ack),
    .ctrl_byte (ctrl_byte),
    .cmd_byte  (cmd_byte),
    .vect_byte (vect_byte),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .cmd_pend  (cmd_pend)
  );

  // DSP control register
  always_comb begin
    ctl_en = d_wr_ctl;
    ctl_d  = d_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  // DSP read mux
  always_comb begin
    d_rdata = '0;
    unique case (dsp_sel_e'(d_sel))
      DS_CTRL: d_rdata[CTL_W-1:0] = ctl_q;
      DS_STAT: begin
        d_rdata[B_FULL]   = hrdf;
        d_rdata[B_EMPTY]  = htde;
        d_rdata[B_CMD]    = cmd_pend;
        d_rdata[B_FLAG_A] = flag_a;
        d_rdata[B_FLAG_B] = flag_b;
        d_rdata[B_DMA]    = 1'b0;
      end
      DS_DATA: d_rdata = hrdf ? rx_word : EMPTY_WORD;
      default: d_rdata = '0;
    endcase
  end

  // host read mux
  always_comb begin
    h_rdata = '0;
    unique case (host_addr_e'(h_addr))
      HA_CTRL: h_rdata = ctrl_byte;
      HA_CMD:  h_rdata = cmd_byte;
      HA_STAT: begin
        h_rdata[B_FULL]   = rxdf;
        h_rdata[B_EMPTY]  = txde;
        h_rdata[B_FLAG_A] = ctl_q[B_FLAG_A];
        h_rdata[B_FLAG_B] = ctl_q[B_FLAG_B];
      end
      HA_VECT: h_rdata = vect_byte;
      HA_BHI:  h_rdata = rxdf ? rx_hi : EMPTY_BYTE;
      HA_BLO:  h_rdata = rxdf ? rx_lo : EMPTY_BYTE;
      default: h_rdata = '0;
    endcase
  end

  assign irq_rx  = hrdf     && ctl_q[B_FULL];
  assign irq_tx  = htde     && ctl_q[B_EMPTY];
  assign irq_cmd = cmd_pend && ctl_q[B_CMD];

  // R9: with all enables off no request may be raised
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_q[2:0] == 3'b000) |-> !(irq_rx || irq_tx || irq_cmd));

  // R8: the DSP-to-host flags follow a control write at the next edge
  a_r8_flags_follow: assert property (@(posedge clk) disable iff (!rst_q_n)
    d_wr_ctl |=> (ctl_q[B_FLAG_B:B_FLAG_A] == $past(d_wdata[B_FLAG_B:B_FLAG_A])));
endmodule

// File: tb/test_hostif_mailbox.sv
`timescale 1ns/1ps
module test_hostif_mailbox;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  d_sel;
  logic        d_wr, d_rd;
  logic [15:0] d_wdata;
  logic [15:0] d_rdata;
  logic        cmd_ack;
  logic        irq_rx, irq_tx, irq_cmd;
  logic [2:0]  h_addr;
  logic        h_wr, h_rd;
  logic [7:0]  h_wdata;
  logic [7:0]  h_rdata;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hostif_mailbox i_hostif_mailbox (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_sel   (d_sel),
    .d_wr    (d_wr),
    .d_rd    (d_rd),
    .d_wdata (d_wdata),
    .d_rdata (d_rdata),
    .cmd_ack (cmd_ack),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx),
    .irq_cmd (irq_cmd),
    .h_addr  (h_addr),
    .h_wr    (h_wr),
    .h_rd    (h_rd),
    .h_wdata (h_wdata),
    .h_rdata (h_rdata)
  );

  // reference state, derived from the requirements
  logic       m_txde, m_hrdf, m_htde, m_rxdf;
  logic [7:0] m_txh, m_txl, m_rxh, m_rxl, m_ivr;
  logic [15:0] m_rxw, m_txw;
  logic [4:0] m_ctl, m_vec;
  logic       m_rreq, m_treq, m_hf0, m_hf1, m_hc;

  task automatic model_reset();
    m_txde = 1; m_hrdf = 0; m_htde = 1; m_rxdf = 0;
    m_txh = 0; m_txl = 0; m_rxh = 0; m_rxl = 0; m_ivr = 0;
    m_rxw = 0; m_txw = 0; m_ctl = 0; m_vec = 5'h16;
    m_rreq = 0; m_treq = 0; m_hf0 = 0; m_hf1 = 0; m_hc = 0;
  endtask

  function automatic logic [7:0] exp_h(input logic [2:0] a);
    case (a)
      3'd0: exp_h = {3'b0, m_hf1, m_hf0, 1'b0, m_treq, m_rreq};
      3'd1: exp_h = {m_hc, 2'b0, m_vec};
      3'd2: exp_h = {3'b0, m_ctl[4], m_ctl[3], 1'b0, m_txde, m_rxdf};
      3'd3: exp_h = m_ivr;
      3'd6: exp_h = m_rxdf ? m_rxh : 8'hBF;
      3'd7: exp_h = m_rxdf ? m_rxl : 8'hBF;
      default: exp_h = 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] exp_d(input logic [1:0] s);
    case (s)
      2'd0: exp_d = {11'b0, m_ctl};
      2'd1: exp_d = {11'b0, m_hf1, m_hf0, m_hc, m_htde, m_hrdf};
      2'd2: exp_d = m_hrdf ? m_rxw : 16'hBEEF;
      default: exp_d = 16'h0000;
    endcase
  endfunction

  function automatic string htag(input logic [2:0] a);
    case (a)
      3'd0, 3'd2: htag = "R8";
      3'd1: htag = "R7";
      3'd3, 3'd4, 3'd5: htag = "R10";
      default: htag = "R6";
    endcase
  endfunction

  function automatic string dtag(input logic [1:0] s);
    case (s)
      2'd1: dtag = "R8";
      2'd2: dtag = "R4";
      default: dtag = "R10";
    endcase
  endfunction

  task automatic chk(input string tg, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tg, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at the falling edge, check, then advance the model
  task automatic cyc(input string tg,
                     input bit hw, input bit hr, input logic [2:0] ha, input logic [7:0] hd,
                     input bit dw, input bit dr, input logic [1:0] ds, input logic [15:0] dd,
                     input bit ack);
    logic xh, xd;
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    d_wr = dw; d_rd = dr; d_sel = ds; d_wdata = dd; cmd_ack = ack;
    #1;
    if (hr) chk((tg == "") ? htag(ha) : tg, {8'h00, h_rdata}, {8'h00, exp_h(ha)});
    if (dr) chk((tg == "") ? dtag(ds) : tg, d_rdata, exp_d(ds));
    chk("R9 irq", {13'b0, irq_cmd, irq_tx, irq_rx},
        {13'b0, m_hc & m_ctl[2], m_htde & m_ctl[1], m_hrdf & m_ctl[0]});
    @(posedge clk);
    xh = !m_txde && !m_hrdf;
    xd = !m_htde && !m_rxdf;
    if (hw && ha == 3'd6 && m_txde) m_txh = hd;
    if (hw && ha == 3'd7 && m_txde) begin m_txl = hd; m_txde = 0; end
    if (dr && ds == 2'd2 && m_hrdf) m_hrdf = 0;
    if (xh) begin m_rxw = {m_txh, m_txl}; m_txde = 1; m_hrdf = 1; end
    if (hr && ha == 3'd7 && m_rxdf) m_rxdf = 0;
    if (xd) begin m_rxh = m_txw[15:8]; m_rxl = m_txw[7:0]; m_htde = 1; m_rxdf = 1; end
    if (dw && ds == 2'd2) begin m_txw = dd; m_htde = 0; end
    if (dw && ds == 2'd0) m_ctl = dd[4:0];
    if (hw && ha == 3'd0) begin m_rreq = hd[0]; m_treq = hd[1]; m_hf0 = hd[3]; m_hf1 = hd[4]; end
    if (ack) m_hc = 0;
    if (hw && ha == 3'd1) begin m_hc = hd[7]; m_vec = hd[4:0]; end
    if (hw && ha == 3'd3) m_ivr = hd;
    @(negedge clk);
  endtask

  task automatic hwr(input string tg, input logic [2:0] a, input logic [7:0] v);
    cyc(tg, 1, 0, a, v, 0, 0, 2'd3, 16'h0, 0);
  endtask
  task automatic hrd(input string tg, input logic [2:0] a);
    cyc(tg, 0, 1, a, 8'h0, 0, 0, 2'd3, 16'h0, 0);
  endtask
  task automatic dwr(input string tg, input logic [1:0] s, input logic [15:0] v);
    cyc(tg, 0, 0, 3'd4, 8'h0, 1, 0, s, v, 0);
  endtask
  task automatic drd(input string tg, input logic [1:0] s);
    cyc(tg, 0, 0, 3'd4, 8'h0, 0, 1, s, 16'h0, 0);
  endtask
  task automatic idle();
    cyc("", 0, 0, 3'd4, 8'h0, 0, 0, 2'd3, 16'h0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
    d_wr = 0; d_rd = 0; d_sel = 0; d_wdata = 0; cmd_ack = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset values, with literal expectations
    h_addr = 3'd2; d_sel = 2'd1; #1;
    chk("R1 host status", {8'h0, h_rdata}, 16'h0002);
    chk("R1 dsp status", d_rdata, 16'h0002);
    h_addr = 3'd1; d_sel = 2'd0; #1;
    chk("R1 command", {8'h0, h_rdata}, 16'h0016);
    chk("R1 dsp control", d_rdata, 16'h0000);
    chk("R1 irqs", {13'b0, irq_cmd, irq_tx, irq_rx}, 16'h0);
    @(negedge clk);

    // R3/R4 host word to DSP, then empty read
    hwr("R2", 3'd6, 8'h12);
    hwr("R2", 3'd7, 8'h34);
    idle();
    drd("R3", 2'd1);
    drd("R4", 2'd2);
    drd("R4", 2'd2);
    // R2 fill both stages, third pair dropped
    hwr("R2", 3'd6, 8'hAA); hwr("R2", 3'd7, 8'hBB); idle();
    hwr("R2", 3'd6, 8'hCC); hwr("R2", 3'd7, 8'hDD);
    hrd("R2", 3'd2);
    hwr("R2", 3'd6, 8'hEE); hwr("R2", 3'd7, 8'hFF);
    drd("R2", 2'd2); idle(); drd("R2", 2'd2); drd("R4", 2'd2);

    // R5/R11 back-to-back DSP writes
    hrd("R6", 3'd6);
    dwr("R11", 2'd2, 16'hA1B2);
    dwr("R11", 2'd2, 16'hC3D4);
    drd("R5", 2'd1);
    hrd("R11", 3'd6); hrd("R6", 3'd6); hrd("R11", 3'd7);
    idle();
    hrd("R11", 3'd6); hrd("R11", 3'd7); hrd("R6", 3'd7);

    // R7 command, ack, and ack colliding with a write
    dwr("R9", 2'd0, 16'h0007);
    hwr("R7", 3'd1, 8'h85);
    drd("R7", 2'd1); hrd("R7", 3'd1);
    cyc("R7", 0, 0, 3'd4, 8'h0, 0, 1, 2'd1, 16'h0, 1);
    drd("R7", 2'd1);
    cyc("R7", 1, 0, 3'd1, 8'h93, 0, 0, 2'd3, 16'h0, 1);
    drd("R7", 2'd1); hrd("R7", 3'd1);

    // R8 flag crossing
    hwr("R8", 3'd0, 8'hFF);
    hrd("R8", 3'd0); drd("R8", 2'd1);
    dwr("R8", 2'd0, 16'h0018);
    hrd("R8", 3'd2);

    // R10 ignored writes and zero addresses
    hwr("R10", 3'd2, 8'hFF); hrd("R10", 3'd2);
    hwr("R10", 3'd4, 8'hFF); hrd("R10", 3'd4);
    hwr("R10", 3'd5, 8'h5A); hrd("R10", 3'd5); hrd("R10", 3'd0); hrd("R10", 3'd1);
    hwr("R10", 3'd3, 8'h3C); hrd("R10", 3'd3);
    drd("R10", 2'd3);

    // seeded random traffic
    void'($urandom(32'd4242));
    for (int i = 0; i < 6000; i++) begin
      bit hw, hr, dw, dr, ack;
      logic [2:0] ha;
      logic [1:0] ds;
      hw  = ($urandom % 4) == 0;
      hr  = !hw && (($urandom % 3) == 0);
      ha  = (($urandom % 2) == 0) ? 3'($urandom % 8) : 3'(6 + ($urandom % 2));
      dw  = ($urandom % 5) == 0;
      dr  = !dw && (($urandom % 3) == 0);
      ds  = 2'($urandom % 4);
      ack = ($urandom % 16) == 0;
      cyc("", hw, hr, ha, 8'($urandom), dw, dr, ds, 16'($urandom), ack);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule